// File: doc/BRIEF.md
# Processor Carry Flag Update Unit

This block is the carry logic on the ALU side of a small 32-bit soft processor. It holds the machine status carry bit. For each executed operation it works out a combinational result and decides whether that result's carry replaces the stored flag. By default the flag holds its value. Only three kinds of operation may overwrite it: add or reverse-subtract without the keep modifier, single-bit right shifts, and explicit status-register writes.

Because the flag holds by default, a carry produced by the low half of a multi-word addition survives any number of unrelated operations before the high half uses it. Those operations include keep-form arithmetic, idle cycles, and the instructions of an interrupt handler.

Top module: `carry_flag_unit`

## Requirements
- R1: Asynchronous active-low reset clears `carry_o` to 0.
- R2: With `op_i`=1 (add), `result_o` equals A + B + cin within the same cycle. cin is 0 when `use_carry_i` is 0, and the stored carry when it is 1.
- R3: With `op_i`=2 (reverse-subtract), `result_o` equals B + ~A + cin. cin is 1 when `use_carry_i` is 0, and the stored carry when it is 1.
- R4: An add or reverse-subtract with `keep_i`=0 and `valid_i`=1 loads its carry-out (bit 32 of the full sum) into `carry_o` at the clock edge.
- R5: An add or reverse-subtract with `keep_i`=1 leaves `carry_o` unchanged, whatever the value of `use_carry_i`.
- R6: With `op_i`=3 (right shift), `result_o` is A shifted right by one bit. `shift_sel_i` selects what enters the MSB: 0 copies A[31] (arithmetic), 1 inserts the stored carry, and 2 or 3 insert zero (logical).
- R7: A valid right shift loads A[0] into `carry_o` for every shift variant, and `keep_i` has no effect on this.
- R8: With `op_i`=4 (status write), `result_o` equals A, and a valid status write loads A[CARRY_POS] (bit 2 by default) into `carry_o`.
- R9: With `op_i`=0 (other), `result_o` is 0 and `carry_o` is unchanged.
- R10: With `valid_i`=0, `carry_o` is unchanged for any operation.
- R11: Consider a non-keep add of the low words, followed by any number of other, keep-form or idle cycles, followed by an add that uses the carry on the high words. The two results form the correct 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation executes this cycle |
| op_i | input | 3 | Operation class: 0 other, 1 add, 2 reverse-subtract, 3 shift right, 4 status write |
| keep_i | input | 1 | Keep modifier: arithmetic leaves the flag alone |
| use_carry_i | input | 1 | Use stored carry as carry-in |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| shift_sel_i | input | 2 | Shift variant select |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Stored carry flag |

## Verification
The assertions assume that `op_i` carries only the five defined codes and that all inputs are settled before the sampling edge. The bench drives every input on the falling edge and uses only codes 0 to 4. Its single check of shift select 3 confirms that this value behaves like the logical shift. A reference model in the bench tracks the flag independently, so any hold, update or idle sequence is predicted without looking inside the design.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef enum logic [2:0] {
    OP_OTHER = 3'd0,
    OP_ADD   = 3'd1,
    OP_RSUB  = 3'd2,
    OP_SHR   = 3'd3,
    OP_SWR   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SH_ARITH = 2'd0,
    SH_CARRY = 2'd1,
    SH_LOGIC = 2'd2,
    SH_RSVD  = 2'd3
  } sh_e;
endpackage

// File: rtl/cfu_addsub.sv
module cfu_addsub #(
  parameter int W = 32
) (
  input  logic         sub_i,
  input  logic         use_c_i,
  input  logic         flag_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] a_x;
  logic         cin;
  logic [W:0]   full;

  // reverse-subtract: B + ~A + cin, default cin=1
  assign a_x  = sub_i ? ~a_i : a_i;
  assign cin  = use_c_i ? flag_i : sub_i;
  assign full = {1'b0, a_x} + {1'b0, b_i} + {{W{1'b0}}, cin};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/cfu_shifter.sv
module cfu_shifter #(
  parameter int W = 32
) (
  input  logic [1:0]   sel_i,
  input  logic         flag_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  import cfu_pkg::*;
  logic msb;

  always_comb begin
    case (sh_e'(sel_i))
      SH_ARITH: msb = a_i[W-1];
      SH_CARRY: msb = flag_i;
      default:  msb = 1'b0;
    endcase
  end

  assign res_o  = {msb, a_i[W-1:1]};
  assign cout_o = a_i[0];
endmodule

// File: rtl/carry_flag_unit.sv
module carry_flag_unit #(
  parameter int W         = 32,
  parameter int CARRY_POS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [2:0]   op_i,
  input  logic         keep_i,
  input  logic         use_carry_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [1:0]   shift_sel_i,
  output logic [W-1:0] result_o,
  output logic         carry_o
);
  import cfu_pkg::*;

  localparam int POS = (CARRY_POS < W) ? CARRY_POS : 0;

  op_e          op;
  logic [W-1:0] as_res, sh_res;
  logic         as_c, sh_c, swr_c;
  logic         c_we, c_nxt;

  assign op = op_e'(op_i);

  cfu_addsub #(.W(W)) u_addsub (
    .sub_i   (op == OP_RSUB),
    .use_c_i (use_carry_i),
    .flag_i  (carry_o),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .sum_o   (as_res),
    .cout_o  (as_c)
  );

  cfu_shifter #(.W(W)) u_shifter (
    .sel_i  (shift_sel_i),
    .flag_i (carry_o),
    .a_i    (opa_i),
    .res_o  (sh_res),
    .cout_o (sh_c)
  );

  generate
    if (W > 1) begin : g_swr
      assign swr_c = opa_i[POS];
    end else begin : g_swr1
      assign swr_c = opa_i[0];
    end
  endgenerate

  // default is hold; only listed ops may write the flag
  always_comb begin
    c_we     = 1'b0;
    c_nxt    = carry_o;
    result_o = '0;
    case (op)
      OP_ADD, OP_RSUB: begin
        result_o = as_res;
        c_we     = ~keep_i;
        c_nxt    = as_c;
      end
      OP_SHR: begin
        result_o = sh_res;
        c_we     = 1'b1;
        c_nxt    = sh_c;
      end
      OP_SWR: begin
        result_o = opa_i;
        c_we     = 1'b1;
        c_nxt    = swr_c;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                carry_o <= 1'b0;
    else if (valid_i && c_we)   carry_o <= c_nxt;
  end

  // R5
  keep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && keep_i && (op_i == 3'd1 || op_i == 3'd2)) |=> $stable(carry_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(carry_o));

  // R9
  other_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0) |-> (result_o == '0));

  // R7
  shift_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3) |=> (carry_o == $past(opa_i[0])));

  // R8
  status_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> (carry_o == $past(opa_i[POS])));

  // R4
  arith_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !keep_i && op_i == 3'd1 && !use_carry_i) |=>
      (carry_o == ({1'b0, $past(opa_i)} + {1'b0, $past(opb_i)} > {1'b0, {W{1'b1}}})));
endmodule

// File: tb/carry_flag_unit_bench.sv
module carry_flag_unit_bench;
  localparam int W = 32;

  typedef struct packed {
    logic [2:0]   op;
    logic         keep;
    logic         uc;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [1:0]   sh;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 2'd0},
    '{3'd1, 1'b0, 1'b1, 32'h0000_0010, 32'h0000_0020, 2'd0},
    '{3'd1, 1'b0, 1'b0, 32'h1234_5678, 32'h1111_1111, 2'd0},
    '{3'd2, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0009, 2'd0},
    '{3'd2, 1'b0, 1'b0, 32'h0000_0009, 32'h0000_0005, 2'd0},
    '{3'd2, 1'b0, 1'b1, 32'h0000_0001, 32'h0000_0003, 2'd0},
    '{3'd3, 1'b0, 1'b0, 32'h8000_0003, 32'h0,         2'd0},
    '{3'd3, 1'b1, 1'b0, 32'h0000_0004, 32'h0,         2'd1},
    '{3'd3, 1'b0, 1'b0, 32'hF000_0001, 32'h0,         2'd2},
    '{3'd3, 1'b0, 1'b0, 32'h8000_0000, 32'h0,         2'd1},
    '{3'd3, 1'b0, 1'b0, 32'hC000_0001, 32'h0,         2'd3},
    '{3'd4, 1'b0, 1'b0, 32'h0000_0004, 32'h0,         2'd0},
    '{3'd1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0},
    '{3'd4, 1'b0, 1'b0, 32'hFFFF_FFFB, 32'h0,         2'd0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [2:0]   op = '0;
  logic         keep = 1'b0, uc = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [1:0]   sh = '0;
  logic [W-1:0] result;
  logic         carry;

  int n_chk = 0;
  int n_fail = 0;
  logic m_c = 1'b0;

  always #2.5 clk = ~clk;

  carry_flag_unit u_carry_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .keep_i(keep),
    .use_carry_i(uc), .opa_i(a), .opb_i(b), .shift_sel_i(sh),
    .result_o(result), .carry_o(carry)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model from the requirements
  task automatic model(input vec_t v, input logic vld, output logic [W-1:0] r, output logic c_n,
                       output string rq);
    logic [W:0] s;
    logic       cin;
    r = '0; c_n = m_c; rq = "R9";
    case (v.op)
      3'd1: begin
        cin = v.uc ? m_c : 1'b0;
        s = {1'b0, v.a} + {1'b0, v.b} + {{W{1'b0}}, cin};
        r = s[W-1:0]; rq = "R2";
        if (!v.keep) c_n = s[W];
      end
      3'd2: begin
        cin = v.uc ? m_c : 1'b1;
        s = {1'b0, ~v.a} + {1'b0, v.b} + {{W{1'b0}}, cin};
        r = s[W-1:0]; rq = "R3";
        if (!v.keep) c_n = s[W];
      end
      3'd3: begin
        rq = "R6";
        if (v.sh == 2'd0)      r = {v.a[W-1], v.a[W-1:1]};
        else if (v.sh == 2'd1) r = {m_c, v.a[W-1:1]};
        else                   r = {1'b0, v.a[W-1:1]};
        c_n = v.a[0];
      end
      3'd4: begin r = v.a; c_n = v.a[2]; rq = "R8"; end
      default: ;
    endcase
    if (!vld) c_n = m_c;
  endtask

  task automatic step(input vec_t v, input logic vld, input string creq);
    logic [W-1:0] er;
    logic         ec;
    string        rq;
    @(negedge clk);
    valid = vld; op = v.op; keep = v.keep; uc = v.uc; a = v.a; b = v.b; sh = v.sh;
    #1;
    model(v, vld, er, ec, rq);
    check(rq, result, er);
    @(posedge clk); #1;
    check(creq, {31'b0, carry}, {31'b0, ec});
    m_c = ec;
  endtask

  function automatic string creq_of(input vec_t v);
    if (v.op == 3'd3) return "R7";
    if (v.op == 3'd4) return "R8";
    if (v.op == 3'd0) return "R9";
    return v.keep ? "R5" : "R4";
  endfunction

  initial begin
    vec_t v;
    logic [W-1:0] lo, hi;
    #12;
    check("R1", {31'b0, carry}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) step(VEC[i], 1'b1, creq_of(VEC[i]));

    // R10: idle cycle with carry-producing op
    step('{3'd4, 1'b0, 1'b0, 32'h4, 32'h0, 2'd0}, 1'b1, "R8");
    step('{3'd1, 1'b0, 1'b0, 32'h0, 32'h0, 2'd0}, 1'b0, "R10");
    step('{3'd3, 1'b0, 1'b0, 32'h0, 32'h0, 2'd2}, 1'b0, "R10");

    // R11: 64-bit add split across intervening work
    step('{3'd1, 1'b0, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 2'd0}, 1'b1, "R4");
    lo = result;
    step('{3'd0, 1'b0, 1'b0, 32'h5, 32'h7, 2'd0}, 1'b1, "R9");
    step('{3'd1, 1'b1, 1'b1, 32'h1, 32'h2, 2'd0}, 1'b1, "R5");
    step('{3'd2, 1'b1, 1'b0, 32'h9, 32'h1, 2'd0}, 1'b1, "R5");
    step('{3'd1, 1'b0, 1'b0, 32'h0, 32'h0, 2'd0}, 1'b0, "R10");
    v = '{3'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 2'd0};
    @(negedge clk);
    valid = 1'b1; op = v.op; keep = v.keep; uc = v.uc; a = v.a; b = v.b; sh = v.sh;
    #1 hi = result;
    check("R11", {hi, lo} >> 32, 32'h1);
    check("R11", lo, 32'h0);
    @(posedge clk); #1;
    check("R11", {31'b0, carry}, 32'd1);

    // R1: reset mid-run
    @(negedge clk); valid = 1'b0; rst_n = 1'b0; #1;
    check("R1", {31'b0, carry}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule